// File: doc/BRIEF.md
# DDR Serial Lane Transmitter

This block turns one 16-bit sample per frame into a double-data-rate serial lane. It sends a bit clock and a frame marker with the data, so a receiver can capture one bit on every edge of the bit clock and find where each word starts. Everything runs on one fast reference clock, `clk`, with twelve `clk` ticks per bit-clock period. Each serial bit lasts six ticks, which is half a bit-clock period. A frame holds eight bits, so it lasts 48 ticks, or four bit-clock periods. The lane carries the upper byte of the sample, `in_data[15:8]`. The lower byte belongs to a second lane that is not part of this block.

Samples arrive on a valid/ready stream. `in_ready` is high for exactly one tick per frame, the last tick. A word is taken on the rising edge where `in_valid` and `in_ready` are both high. A producer that raises `in_valid` early must hold `in_valid` and `in_data` steady until that edge; it is back-pressured for the rest of the frame. If no word is offered at the boundary, the lane keeps running and sends the previous word again.

The bit order and the bit-clock phase come from plain control pins. Both are sampled only at the frame boundary, so a frame on the wire always has one consistent setting.

Top module: `ddr_lane_serializer`

## Requirements
- R1: `frame_mark` repeats every 48 ticks. It is high for the first 24 ticks of each frame and low for the last 24. Its rising tick is the first tick of bit slot 0.
- R2: `ser_clk` has a period of 12 ticks and is high for 6 ticks of each period, so each frame holds four bit-clock periods.
- R3: Frame tick t (0..47, counted from the `frame_mark` rise) carries bit slot t/6. `ser_data` changes only where one slot ends and the next begins.
- R4: With `lsb_first` = 0, slots 0..7 carry `in_data` bits 15, 14, ..., 8, in that order.
- R5: With `lsb_first` = 1, slots 0..7 carry `in_data` bits 8, 9, ..., 15, in that order.
- R6: With `clk_phase` = c, `ser_clk` rises at frame ticks d, d+12, d+24 and d+36, where d = (3 + 2c) mod 12. Code 0 places the rising edge 90° after a bit edge, and each code step adds 60°. Codes 6 and 7 act like codes 0 and 1.
- R7: `in_ready` is high only on frame tick 46 as seen by the bench, which is the last tick before the next frame starts. An accepted word is sent in the frame that starts right after the handshake edge. While `in_ready` is low, a pending word does not change the frame in flight.
- R8: If `in_valid` is low on the boundary tick, the next frame sends the previous word again.
- R9: A change of `lsb_first` or `clk_phase` in the middle of a frame leaves that frame unchanged and takes effect from the next frame.
- R10: While `rst_n` is low, `ser_data`, `ser_clk` and `frame_mark` are 0. The stored word resets to zero, so the first frame after reset sends all zeros with order code 0 and phase code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, 12 ticks per bit-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample word offered |
| in_ready | output | 1 | Block takes the word on this tick (last tick of the frame) |
| in_data | input | 16 | Parallel sample; the lane sends bits 15..8 |
| lsb_first | input | 1 | 0: highest bit first; 1: lowest lane bit first |
| clk_phase | input | 3 | Bit-clock phase code, in 60° steps from the 90° default |
| ser_data | output | 1 | Serial data, one bit per bit-clock half period |
| ser_clk | output | 1 | Bit clock; capture on both edges |
| frame_mark | output | 1 | Frame marker, high for the first half of each frame |

## Verification
The bench aims at the corner cases listed below.

- **Both bit orders.** A design that mirrored the wrong byte, or that lost a slot at the order switch, would show a wrong bit in one slot.
- **Every phase code, including the two codes that wrap.** A design with an off-by-one tick delay, or one that let code 6 or 7 run past the period, would move the bit-clock rising edge to the wrong tick.
- **A settings change in mid-frame.** A design that sampled the settings at the wrong time would change the bit order or the bit-clock phase inside the frame already on the wire.
- **A word offered early and held.** A design that took the word before the boundary would corrupt the frame in flight.
- **A boundary with no word.** A design that cleared the stored word, instead of sending it again, would send zeros.

// File: rtl/serlane_pkg.sv
package serlane_pkg;
  localparam int unsigned PHASE_CODE_W = 3;

  typedef struct packed {
    logic                    lsb_first;
    logic [PHASE_CODE_W-1:0] phase_code;
  } lane_cfg_t;
endpackage

// File: rtl/serlane_frame_timer.sv
module serlane_frame_timer #(
  parameter int unsigned TICKS_PER_FRAME = 48,
  parameter int unsigned CW              = $clog2(TICKS_PER_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_FRAME - 1);

  // Reset to the last tick so the first edge after reset is a boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= LAST;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST);

  // R7: the boundary tick never lasts more than one cycle.
  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !last_o);
endmodule

// File: rtl/serlane_loader.sv
module serlane_loader
  import serlane_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 16,
  parameter int unsigned FRAME_BITS    = 8,
  parameter int unsigned TICKS_PER_BIT = 6,
  parameter int unsigned CW            = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CW-1:0]       cnt_i,
  input  logic                last_i,
  input  logic                in_valid_i,
  input  logic [SAMPLE_W-1:0] in_data_i,
  input  lane_cfg_t           cfg_i,
  output lane_cfg_t           cfg_o,
  output logic                ser_data_o,
  output logic                mark_o
);
  localparam int unsigned BW              = $clog2(FRAME_BITS);
  localparam int unsigned TICKS_PER_FRAME = FRAME_BITS * TICKS_PER_BIT;
  localparam int unsigned HALF_FRAME      = TICKS_PER_FRAME / 2;

  logic [SAMPLE_W-1:0]   word_q;
  lane_cfg_t             cfg_q;
  logic [FRAME_BITS-1:0] lane_bits;
  logic [FRAME_BITS-1:0] rev_bits;
  logic [FRAME_BITS-1:0] pick_bits;
  logic [BW-1:0]         bit_idx;

  // Word and settings change only at the frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cfg_q  <= '0;
    end else if (last_i) begin
      if (in_valid_i) word_q <= in_data_i;
      cfg_q <= cfg_i;
    end
  end

  assign lane_bits = word_q[SAMPLE_W-1 -: FRAME_BITS];

  // Slot k gets lane bit FRAME_BITS-1-k when the highest bit goes first.
  for (genvar g = 0; g < FRAME_BITS; g++) begin : g_rev
    assign rev_bits[g] = lane_bits[FRAME_BITS-1-g];
  end

  assign pick_bits = cfg_q.lsb_first ? lane_bits : rev_bits;
  assign bit_idx   = BW'(cnt_i / CW'(TICKS_PER_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_data_o <= 1'b0;
      mark_o     <= 1'b0;
    end else begin
      ser_data_o <= pick_bits[bit_idx];
      mark_o     <= (32'(cnt_i) < HALF_FRAME);
    end
  end

  assign cfg_o = cfg_q;

  // R3: serial data moves only one tick after a slot boundary was counted.
  p_bit_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data_o) |-> ((32'(cnt_i) % TICKS_PER_BIT) == 1));
  // R9: settings register updates only as the frame counter wraps.
  p_cfg_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> (cnt_i == '0));
  // R7: the word register updates only as the frame counter wraps.
  p_word_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> (cnt_i == '0));
endmodule

// File: rtl/serlane_clkgen.sv
module serlane_clkgen
  import serlane_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT    = 6,
  parameter int unsigned PHASE_DEF_TICKS  = 3,
  parameter int unsigned PHASE_STEP_TICKS = 2,
  parameter int unsigned CW               = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           cnt_i,
  input  logic [PHASE_CODE_W-1:0] phase_code_i,
  output logic                    ser_clk_o
);
  localparam int unsigned PERIOD = 2 * TICKS_PER_BIT;

  int unsigned pos;
  int unsigned dly;
  int unsigned rel;

  always_comb begin
    pos = 32'(cnt_i) % PERIOD;
    dly = (PHASE_DEF_TICKS + PHASE_STEP_TICKS * 32'(phase_code_i)) % PERIOD;
    rel = (pos + PERIOD - dly) % PERIOD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_clk_o <= 1'b0;
    else        ser_clk_o <= (rel < TICKS_PER_BIT);
  end

  // R6: bit-clock edges never fall on a data edge, except where a new
  // phase code starts at the frame boundary.
  p_clk_off_data_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_clk_o) |-> (((32'(cnt_i) % TICKS_PER_BIT) != 1) || (cnt_i == CW'(1))));
endmodule

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer
  import serlane_pkg::*;
#(
  parameter int unsigned SAMPLE_W         = 16,
  parameter int unsigned FRAME_BITS       = 8,
  parameter int unsigned TICKS_PER_BIT    = 6,
  parameter int unsigned PHASE_DEF_TICKS  = 3,
  parameter int unsigned PHASE_STEP_TICKS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMPLE_W-1:0]     in_data,
  input  logic                    lsb_first,
  input  logic [PHASE_CODE_W-1:0] clk_phase,
  output logic                    ser_data,
  output logic                    ser_clk,
  output logic                    frame_mark
);
  localparam int unsigned TICKS_PER_FRAME = FRAME_BITS * TICKS_PER_BIT;
  localparam int unsigned CW              = $clog2(TICKS_PER_FRAME);

  logic [CW-1:0] cnt;
  logic          last;
  lane_cfg_t     cfg_in;
  lane_cfg_t     cfg_act;

  assign cfg_in   = lane_cfg_t'({lsb_first, clk_phase});
  assign in_ready = last;

  serlane_frame_timer #(
    .TICKS_PER_FRAME(TICKS_PER_FRAME),
    .CW             (CW)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt),
    .last_o(last)
  );

  serlane_loader #(
    .SAMPLE_W     (SAMPLE_W),
    .FRAME_BITS   (FRAME_BITS),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .CW           (CW)
  ) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt),
    .last_i    (last),
    .in_valid_i(in_valid),
    .in_data_i (in_data),
    .cfg_i     (cfg_in),
    .cfg_o     (cfg_act),
    .ser_data_o(ser_data),
    .mark_o    (frame_mark)
  );

  serlane_clkgen #(
    .TICKS_PER_BIT   (TICKS_PER_BIT),
    .PHASE_DEF_TICKS (PHASE_DEF_TICKS),
    .PHASE_STEP_TICKS(PHASE_STEP_TICKS),
    .CW              (CW)
  ) u_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt),
    .phase_code_i(cfg_act.phase_code),
    .ser_clk_o   (ser_clk)
  );

  // R1/R7: a frame starts on the wire two edges after a ready tick.
  p_mark_after_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_mark) |-> $past(in_ready, 2));
endmodule

// File: tb/ddr_lane_serializer_tb.sv
module ddr_lane_serializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPB        = 6;
  localparam int TPF        = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        lsb_first;
  logic [2:0]  clk_phase;
  logic        ser_data;
  logic        ser_clk;
  logic        frame_mark;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_lane_serializer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .lsb_first (lsb_first),
    .clk_phase (clk_phase),
    .ser_data  (ser_data),
    .ser_clk   (ser_clk),
    .frame_mark(frame_mark)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string rq, input string what, input int t);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s tick %0d: got 0x%0h expected 0x%0h", rq, what, t, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [15:0] w, input int k, input logic lsb);
    return lsb ? w[8+k] : w[15-k];
  endfunction

  task automatic send_word(input logic [15:0] w, input logic lsb, input logic [2:0] code);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = w;
    lsb_first = lsb;
    clk_phase = code;
    while (in_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Waits for the frame-marker rise, then checks all 48 ticks of the frame.
  task automatic capture_frame(input logic [15:0] w, input logic lsb, input int code,
                               input string note, input int chg_tick, input logic n_lsb,
                               input logic [2:0] n_code, input int vld_tick,
                               input logic [15:0] v_data);
    int d;
    int guard;
    d = (3 + 2 * code) % 12;
    guard = 0;
    while (frame_mark !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (frame_mark !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    chk(guard < 200, 1, {"R1 ", note}, "frame start seen", 0);
    for (int t = 0; t < TPF; t++) begin
      chk(frame_mark, (t < TPF/2), {"R1 ", note}, "frame_mark", t);
      chk(ser_data, exp_bit(w, t / TPB, lsb),
          lsb ? {"R3,R5 ", note} : {"R3,R4 ", note}, "ser_data", t);
      chk(ser_clk, (((t + 12 - d) % 12) < 6), {"R2,R6 ", note}, "ser_clk", t);
      chk(in_ready, (t == TPF-2), {"R7 ", note}, "in_ready", t);
      if (t == chg_tick) begin lsb_first = n_lsb; clk_phase = n_code; end
      if (t == vld_tick) begin in_valid = 1'b1; in_data = v_data; end
      if (t == TPF-1 && vld_tick >= 0) in_valid = 1'b0;
      if (t < TPF-1) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; lsb_first = 1'b0; clk_phase = '0;
    repeat (3) @(negedge clk);
    chk(ser_data,   0, "R10", "ser_data in reset", 0);
    chk(ser_clk,    0, "R10", "ser_clk in reset", 0);
    chk(frame_mark, 0, "R10", "frame_mark in reset", 0);
    rst_n = 1'b1;
    capture_frame(16'h0000, 1'b0, 0, "R10 first frame", -1, 1'b0, 3'd0, -1, 16'h0);
  endtask

  task automatic t_msb_first;
    send_word(16'hB43C, 1'b0, 3'd0);
    capture_frame(16'hB43C, 1'b0, 0, "R4 msb", -1, 1'b0, 3'd0, -1, 16'h0);
  endtask

  task automatic t_lsb_first;
    send_word(16'hC1FF, 1'b1, 3'd0);
    capture_frame(16'hC1FF, 1'b1, 0, "R5 lsb", -1, 1'b0, 3'd0, -1, 16'h0);
  endtask

  task automatic t_phase_sweep;
    for (int c = 0; c < 8; c++) begin
      send_word(16'h6900 ^ 16'(c << 9), 1'b0, 3'(c));
      capture_frame(16'h6900 ^ 16'(c << 9), 1'b0, c, "R6 sweep", -1, 1'b0, 3'd0, -1, 16'h0);
    end
  endtask

  task automatic t_cfg_midframe;
    send_word(16'h5A00, 1'b0, 3'd0);
    capture_frame(16'h5A00, 1'b0, 0, "R9 old cfg holds", 20, 1'b1, 3'd2, -1, 16'h0);
    capture_frame(16'h5A00, 1'b1, 2, "R8,R9 repeat with new cfg", -1, 1'b1, 3'd2, -1, 16'h0);
  endtask

  task automatic t_holdoff;
    capture_frame(16'h5A00, 1'b1, 2, "R7,R8 pending word held off", -1, 1'b1, 3'd2, 10, 16'h3CFF);
    capture_frame(16'h3CFF, 1'b1, 2, "R7 held word sent", -1, 1'b1, 3'd2, -1, 16'h0);
  endtask

  initial begin
    t_reset();
    t_msb_first();
    t_lsb_first();
    t_phase_sweep();
    t_cfg_midframe();
    t_holdoff();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule